// File: doc/BRIEF.md
# Four-Point Inverse Cosine Transform Stage

This block computes one dimension of a four-point inverse cosine transform on signed 16-bit fixed-point data. A valid strobe comes with four coefficients. The block splits the work into an even half and an odd half. The even half forms the wrapped sum and the wrapped difference of coefficients 0 and 2 and scales each one by a single cosine constant. The odd half combines coefficients 1 and 3 through two multiply-accumulates that use the other two constants. All four wide results are rounded, shifted down by the fraction width and clamped back to 16 bits. A final butterfly of wrapping adds and subtracts then produces the four outputs.

The three constants are fixed values with 14 fractional bits: 15137, 11585 and 6270. The butterfly outputs pass through one output register, so a result appears one clock after its input strobe. Two passes of this stage with a transpose between them make a two-dimensional transform, but that surrounding logic lies outside the block.

Top module: `idct4_stage`

## Requirements
- R1: While rst_n is low, out_valid is 0 and all four outputs are 0.
- R2: out_valid equals in_valid from the previous rising clock edge. The result of a strobed input appears on the outputs one cycle after the strobe.
- R3: The even intermediates are A = wrap16(c0 + c2) * 11585 and B = wrap16(c0 - c2) * 11585. wrap16 keeps the low 16 bits as a two's-complement value.
- R4: The odd intermediates are P = c1*6270 - c3*15137 and Q = c1*15137 + c3*6270, computed as 32-bit signed values.
- R5: Each of A, B, P and Q is narrowed as (v + 8192) >>> 14, an arithmetic shift that rounds halves toward positive infinity.
- R6: Each narrowed value is clamped to the range [-32768, 32767] before it enters the butterfly.
- R7: With the narrowed values a, b, p and q: y0 = a + q, y1 = b + p, y2 = b - p and y3 = a - q. Each is taken modulo 2^16 and is not clamped.
- R8: A cycle with in_valid low leaves y0..y3 unchanged, even when the coefficients change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input coefficients valid |
| c0 | input | 16 | Coefficient 0, signed |
| c1 | input | 16 | Coefficient 1, signed |
| c2 | input | 16 | Coefficient 2, signed |
| c3 | input | 16 | Coefficient 3, signed |
| out_valid | output | 1 | Outputs valid |
| y0 | output | 16 | Result 0, signed |
| y1 | output | 16 | Result 1, signed |
| y2 | output | 16 | Result 2, signed |
| y3 | output | 16 | Result 3, signed |

## Verification
The bench builds the block with its default parameters: 16-bit data, 14 fractional bits and the three standard constants. It feeds every four-way combination of eight edge values, among them -32768, -32767, 32767, ±1 and 0. This sweep reaches the wrap of the even sum and difference, saturation of the odd products and wrap in the butterfly. Directed vectors and a random stream then cover ordinary values, strobe gaps and output holding.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
  localparam int DEF_DW   = 16;
  localparam int DEF_FRAC = 14;
  localparam int DEF_K8   = 15137;
  localparam int DEF_K16  = 11585;
  localparam int DEF_K24  = 6270;
endpackage

// File: rtl/idct4_even.sv
module idct4_even #(
  parameter int DW  = 16,
  parameter int PW  = 32,
  parameter int K16 = 11585
) (
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x2,
  output logic signed [PW-1:0] ev_a,
  output logic signed [PW-1:0] ev_b
);
  logic signed [DW-1:0] sum_w, dif_w;
  logic signed [PW-1:0] sum_x, dif_x, k_x;

  always_comb begin
    sum_w = x0 + x2;
    dif_w = x0 - x2;
    sum_x = {{(PW-DW){sum_w[DW-1]}}, sum_w};
    dif_x = {{(PW-DW){dif_w[DW-1]}}, dif_w};
    k_x   = PW'(K16);
    ev_a  = sum_x * k_x;
    ev_b  = dif_x * k_x;
  end
endmodule

// File: rtl/idct4_odd.sv
module idct4_odd #(
  parameter int DW  = 16,
  parameter int PW  = 32,
  parameter int K8  = 15137,
  parameter int K24 = 6270
) (
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] x3,
  output logic signed [PW-1:0] od_p,
  output logic signed [PW-1:0] od_q
);
  logic signed [PW-1:0] x1_x, x3_x, k8_x, k24_x;

  always_comb begin
    x1_x  = {{(PW-DW){x1[DW-1]}}, x1};
    x3_x  = {{(PW-DW){x3[DW-1]}}, x3};
    k8_x  = PW'(K8);
    k24_x = PW'(K24);
    od_p  = x1_x * k24_x - x3_x * k8_x;
    od_q  = x1_x * k8_x + x3_x * k24_x;
  end
endmodule

// File: rtl/idct4_rndsat.sv
module idct4_rndsat #(
  parameter int DW   = 16,
  parameter int PW   = 32,
  parameter int FRAC = 14
) (
  input  logic signed [PW-1:0] wide_in,
  output logic signed [DW-1:0] narrow_out
);
  localparam logic signed [PW:0] RND  = {{(PW-FRAC+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [PW:0] MAXV = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW:0] MINV = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW:0] biased, shifted;

  always_comb begin
    biased  = {wide_in[PW-1], wide_in} + RND;
    shifted = biased >>> FRAC;
    if (shifted > MAXV)      narrow_out = MAXV[DW-1:0];
    else if (shifted < MINV) narrow_out = MINV[DW-1:0];
    else                     narrow_out = shifted[DW-1:0];
  end
endmodule

// File: rtl/idct4_stage.sv
module idct4_stage
  import idct4_pkg::*;
#(
  parameter int DW   = DEF_DW,
  parameter int FRAC = DEF_FRAC,
  parameter int K8   = DEF_K8,
  parameter int K16  = DEF_K16,
  parameter int K24  = DEF_K24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] c0,
  input  logic signed [DW-1:0] c1,
  input  logic signed [DW-1:0] c2,
  input  logic signed [DW-1:0] c3,
  output logic                 out_valid,
  output logic signed [DW-1:0] y0,
  output logic signed [DW-1:0] y1,
  output logic signed [DW-1:0] y2,
  output logic signed [DW-1:0] y3
);
  localparam int PW = 2 * DW;
  localparam int NW = 4;

  logic signed [PW-1:0] wide [NW];
  logic signed [DW-1:0] nar  [NW];
  logic signed [DW-1:0] y0_d, y1_d, y2_d, y3_d;

  idct4_even #(.DW(DW), .PW(PW), .K16(K16)) u_even (
    .x0(c0), .x2(c2), .ev_a(wide[0]), .ev_b(wide[1])
  );

  idct4_odd #(.DW(DW), .PW(PW), .K8(K8), .K24(K24)) u_odd (
    .x1(c1), .x3(c3), .od_p(wide[2]), .od_q(wide[3])
  );

  for (genvar g = 0; g < NW; g++) begin : g_nar
    idct4_rndsat #(.DW(DW), .PW(PW), .FRAC(FRAC)) u_rs (
      .wide_in(wide[g]), .narrow_out(nar[g])
    );
  end

  // Butterfly, wrapping in DW bits: nar = {a, b, p, q}
  always_comb begin
    y0_d = nar[0] + nar[3];
    y1_d = nar[1] + nar[2];
    y2_d = nar[1] - nar[2];
    y3_d = nar[0] - nar[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      y0 <= '0;
      y1 <= '0;
      y2 <= '0;
      y3 <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        y0 <= y0_d;
        y1 <= y1_d;
        y2 <= y2_d;
        y3 <= y3_d;
      end
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(y0) && $stable(y1) && $stable(y2) && $stable(y3)));
  // R6
  q_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide[3][PW-1] |-> !nar[3][DW-1]);
  // R6
  p_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide[2][PW-1] |-> !nar[2][DW-1]);
endmodule

// File: tb/idct4_stage_tb.sv
module idct4_stage_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0;
  logic out_valid;
  logic signed [15:0] y0, y1, y2, y3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idct4_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .c0(c0), .c1(c1), .c2(c2), .c3(c3),
    .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2), .y3(y3)
  );

  function automatic int w16(int v);
    int t;
    t = v & 32'h0000FFFF;
    if (t >= 32768) t = t - 65536;
    return t;
  endfunction

  function automatic int narrow(int v);
    int t;
    t = (v + 8192) >>> 14;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  int ex0, ex1, ex2, ex3;

  task automatic ref_model(input int a0, input int a1, input int a2, input int a3);
    int a, b, p, q;
    a = narrow(w16(a0 + a2) * 11585);
    b = narrow(w16(a0 - a2) * 11585);
    p = narrow(a1 * 6270 - a3 * 15137);
    q = narrow(a1 * 15137 + a3 * 6270);
    ex0 = w16(a + q);
    ex1 = w16(b + p);
    ex2 = w16(b - p);
    ex3 = w16(b - p);
    ex2 = w16(b - p);
    ex3 = w16(a - q);
  endtask

  task automatic check_out(input string tag, input bit ev);
    checks++;
    if (out_valid !== ev || int'(y0) != ex0 || int'(y1) != ex1 ||
        int'(y2) != ex2 || int'(y3) != ex3) begin
      errors++;
      $display("FAIL %s: got v=%0b y=%0d,%0d,%0d,%0d expected v=%0b y=%0d,%0d,%0d,%0d",
               tag, out_valid, y0, y1, y2, y3, ev, ex0, ex1, ex2, ex3);
    end
  endtask

  task automatic apply(input int a0, input int a1, input int a2, input int a3,
                       input string tag);
    @(negedge clk);
    c0 = 16'(a0); c1 = 16'(a1); c2 = 16'(a2); c3 = 16'(a3);
    in_valid = 1'b1;
    ref_model(a0, a1, a2, a3);
    @(posedge clk);
    #1;
    check_out(tag, 1'b1);
  endtask

  int edges [8] = '{-32768, -32767, -1, 0, 1, 8191, -8192, 32767};

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    c0 = 16'sd100; c1 = 16'sd200; c2 = 16'sd300; c3 = 16'sd400;
    ex0 = 0; ex1 = 0; ex2 = 0; ex3 = 0;
    @(posedge clk); #1;
    check_out("R1 reset", 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_out("R2 idle after reset", 1'b0);

    // R3: even sum wraps (32767 + 1 -> -32768), difference wraps too
    apply(32767, 0, 1, 0, "R3 even sum wrap");
    apply(-32768, 0, 1, 0, "R3 even diff wrap");
    apply(1000, 0, -250, 0, "R3 even plain");
    // R4: odd part only
    apply(0, 1234, 0, -567, "R4 odd mac");
    apply(0, -20000, 0, 15000, "R4 odd mac neg");
    // R5: rounding of small values, 16384*? -> x1=1 gives q=15137 -> 1
    apply(0, 1, 0, 0, "R5 round up");
    apply(0, 0, 0, 1, "R5 round small");
    apply(0, -1, 0, 0, "R5 round neg");
    // R6: odd products saturate
    apply(0, 32767, 0, 32767, "R6 sat pos");
    apply(0, -32768, 0, -32768, "R6 sat neg");
    // R7: butterfly wraps
    apply(32767, 32767, -32768, 32767, "R7 butterfly wrap");
    apply(5, 6, 7, 8, "R7 ordering");

    // R8: hold with changed inputs
    @(negedge clk);
    in_valid = 1'b0;
    c0 = 16'sd11; c1 = 16'sd22; c2 = -16'sd33; c3 = 16'sd44;
    @(posedge clk); #1;
    check_out("R8 hold (R2 valid low)", 1'b0);
    @(negedge clk);
    c0 = -16'sd999;
    @(posedge clk); #1;
    check_out("R8 hold second cycle", 1'b0);

    // R6/R7 exhaustive sweep over edge values
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 8; k++)
          for (int m = 0; m < 8; m++)
            apply(edges[i], edges[j], edges[k], edges[m], "R6 R7 edge sweep");

    // R2/R3/R4 random stream with gaps
    for (int n = 0; n < 1500; n++) begin
      int r0, r1, r2, r3;
      r0 = w16($urandom); r1 = w16($urandom);
      r2 = w16($urandom); r3 = w16($urandom);
      apply(r0, r1, r2, r3, "R4 random");
      if (n % 7 == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        c1 = 16'(w16($urandom));
        @(posedge clk); #1;
        check_out("R2 gap", 1'b0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule